// File: doc/BRIEF.md
# Tagged Masked Associative Search Array

This block is a small content-addressable memory. It holds sixteen 128-bit entries and searches a 128-bit comparand against all of them at once. A host reaches every wide register and entry through a 32-bit port, one word at a time. The search returns a match flag, a multiple-match flag and the lowest matching entry number. Each entry carries a two-bit tag. Only entries tagged as valid take part in a search. Entries tagged empty, skipped or RAM-only never match.

Two 128-bit mask registers each work in one of two modes, chosen by a control word. In compare mode, set bits are left out of the search. In write mode, set bits of an entry are protected during a host write. A search starts on its own when the host writes the top word of the comparand or of a mask, or any control word. The host can also start one with a command strike. The result goes into a status register one clock later, with a one-cycle done pulse. After a hit, the host can read every word of the matching entry without giving an address. This includes the part outside the compare mask, which serves as associated data.

Top module: `tagcam`

## Requirements
- R1: While `rst_n` is low at a clock edge, every entry tag becomes empty (01), both masks, the comparand, the control word and the status register are cleared, and `done` is low.
- R2: The tag bits {skip, empty} are encoded as 00 valid, 01 empty, 10 skip and 11 RAM. Only an entry tagged 00 can match, and entries with any other tag are never reported.
- R3: `wr_sel` selects the write target: 0 comparand, 1 mask A, 2 mask B, 3 control, 4 entry data, 5 entry tag. A search starts when word 3 (`wr_word`=3) of the comparand, mask A or mask B is written, when any control word is written, or when `cmp_cmd` is high. A write to words 0 to 2 starts nothing.
- R4: The result is captured one clock after the edge that takes in the trigger. `done` is high for exactly the cycle that follows that capture, and is low in the cycle right after the triggering write.
- R5: Control bit 0 (mask A) and bit 1 (mask B) set to 0 select compare mode. In compare mode, bits set in that mask are ignored by the search.
- R6: A mask whose control bit is 1 acts as a write mask. An entry-data write leaves the masked bits of the addressed word unchanged and replaces the others. A write-mode mask has no effect on a search.
- R7: `hit_addr` is the lowest-numbered matching valid entry, or 0 when nothing matches. `multi` is high only when two or more entries match.
- R8: A status read (`rd_sel`=0) returns match in bit 31, multiple-match in bit 30 and the hit address in bits 3:0, with all other bits zero. The status holds its value between searches.
- R9: A matched read (`rd_sel`=1) returns word `rd_word` of the entry named by the status register when the last search matched, and zero otherwise.
- R10: An entry read (`rd_sel`=2) returns word `rd_word` of entry `rd_addr`. A tag read (`rd_sel`=3) returns that entry's tag in bits 1:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Write target code |
| wr_addr | input | 4 | Entry number for data and tag writes |
| wr_word | input | 2 | 32-bit word index within a 128-bit target |
| wr_data | input | 32 | Write data |
| cmp_cmd | input | 1 | Explicit search command |
| rd_sel | input | 2 | Read source code |
| rd_addr | input | 4 | Entry number for direct reads |
| rd_word | input | 2 | Word index for entry reads |
| rd_data | output | 32 | Combinational read data |
| match | output | 1 | Last search found a valid match |
| multi | output | 1 | Last search found two or more matches |
| hit_addr | output | 4 | Lowest matching entry of the last search |
| done | output | 1 | One-cycle pulse when a new result is captured |

## Verification
The search is first run once per entry with that entry's own contents as the comparand. Every entry holds distinct values, so these runs show whether the reported address is the right one. Each entry is then set to each of the four tags in turn, which shows that only the valid code takes part. Planted duplicates, with the lower copies then skipped or turned into RAM entries, separate lowest-index priority from the multiple-match flag. Mask patterns are swept in both compare and write mode, across words and bits. Together they show whether a mask is applied to the search, to the write, or to neither.

// File: rtl/tagcam_pkg.sv
// Shared codes for the tagged search array: entry tag encoding,
// host write target codes and read source codes.
package tagcam_pkg;

    // Entry tag, bit order {skip, empty}
    typedef enum logic [1:0] {
        TAG_VALID = 2'b00,
        TAG_EMPTY = 2'b01,
        TAG_SKIP  = 2'b10,
        TAG_RAM   = 2'b11
    } tag_e;

    // Host write targets
    localparam logic [2:0] SEL_CMP  = 3'd0;
    localparam logic [2:0] SEL_MSKA = 3'd1;
    localparam logic [2:0] SEL_MSKB = 3'd2;
    localparam logic [2:0] SEL_CTRL = 3'd3;
    localparam logic [2:0] SEL_DATA = 3'd4;
    localparam logic [2:0] SEL_TAG  = 3'd5;

    // Read sources
    localparam logic [1:0] RD_STAT = 2'd0;
    localparam logic [1:0] RD_HIT  = 2'd1;
    localparam logic [1:0] RD_ENT  = 2'd2;
    localparam logic [1:0] RD_TAG  = 2'd3;

endpackage

// File: rtl/tagcam_regs.sv
// Comparand, two mask registers and the mode control word.
// Wide registers load one host word at a time. Produces the search
// trigger and splits the masks into a compare mask and a write mask.
// Assumes DW is a multiple of HW.
module tagcam_regs
    import tagcam_pkg::*;
#(
    parameter int DW = 128,
    parameter int HW = 32,
    localparam int NW = DW / HW,
    localparam int WIW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [WIW-1:0] wr_word,
    input  logic [HW-1:0]  wr_data,
    input  logic           cmp_cmd,
    output logic [DW-1:0]  comparand,
    output logic [DW-1:0]  cmp_mask,
    output logic [DW-1:0]  wr_mask,
    output logic           trigger
);

    logic [DW-1:0] cmp_q;
    logic [DW-1:0] mska_q;
    logic [DW-1:0] mskb_q;
    logic [1:0]    ctrl_q;
    logic          top_word;

    // Load the addressed word of the selected register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mska_q <= '0;
            mskb_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CMP:  cmp_q[wr_word*HW +: HW]  <= wr_data;
                SEL_MSKA: mska_q[wr_word*HW +: HW] <= wr_data;
                SEL_MSKB: mskb_q[wr_word*HW +: HW] <= wr_data;
                SEL_CTRL: ctrl_q <= wr_data[1:0];
                default:  ;
            endcase
        end
    end

    // Split masks by mode: control bit 0 -> compare, 1 -> write
    always_comb begin
        cmp_mask = (ctrl_q[0] ? '0 : mska_q) | (ctrl_q[1] ? '0 : mskb_q);
        wr_mask  = (ctrl_q[0] ? mska_q : '0) | (ctrl_q[1] ? mskb_q : '0);
    end

    // Search trigger: top word of comparand or a mask, any control, or command
    always_comb begin
        top_word = (wr_word == WIW'(NW - 1));
        trigger  = cmp_cmd |
                   (wr_en & (wr_sel == SEL_CTRL)) |
                   (wr_en & top_word &
                    ((wr_sel == SEL_CMP) | (wr_sel == SEL_MSKA) | (wr_sel == SEL_MSKB)));
    end

    assign comparand = cmp_q;

    a_r1_masks_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cmp_mask == '0) && (wr_mask == '0) && (comparand == '0));

    a_r3_partial_word_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_CMP) && (wr_word != WIW'(NW - 1)) && !cmp_cmd) |-> !trigger);

endmodule

// File: rtl/tagcam_array.sv
// Entry storage with per-entry validity tags and the parallel compare.
// Host writes go one word at a time under the write mask. Two read
// ports: port A by host address, port B for the hit entry.
// Assumes one host write per cycle.
module tagcam_array
    import tagcam_pkg::*;
#(
    parameter int DW = 128,
    parameter int HW = 32,
    parameter int NE = 16,
    localparam int NW = DW / HW,
    localparam int WIW = (NW > 1) ? $clog2(NW) : 1,
    localparam int AW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [AW-1:0]  wr_addr,
    input  logic [WIW-1:0] wr_word,
    input  logic [HW-1:0]  wr_data,
    input  logic [DW-1:0]  wr_mask,
    input  logic [DW-1:0]  comparand,
    input  logic [DW-1:0]  cmp_mask,
    input  logic [AW-1:0]  rd_addr_a,
    input  logic [AW-1:0]  rd_addr_b,
    output logic [DW-1:0]  ent_a,
    output logic [1:0]     tag_a,
    output logic [DW-1:0]  ent_b,
    output logic [NE-1:0]  hit_vec
);

    logic [DW-1:0] mem  [NE];
    tag_e          tags [NE];
    logic [HW-1:0] wm_word;

    assign wm_word = wr_mask[wr_word*HW +: HW];

    // Store tags and masked data words for the addressed entry
    always_ff @(posedge clk) begin
        for (int e = 0; e < NE; e++) begin
            if (!rst_n) begin
                mem[e]  <= '0;
                tags[e] <= TAG_EMPTY;
            end else if (wr_en && (wr_addr == AW'(e))) begin
                if (wr_sel == SEL_DATA)
                    mem[e][wr_word*HW +: HW] <=
                        (mem[e][wr_word*HW +: HW] & wm_word) | (wr_data & ~wm_word);
                else if (wr_sel == SEL_TAG)
                    tags[e] <= tag_e'(wr_data[1:0]);
            end
        end
    end

    // One comparator per entry, gated by its valid tag
    for (genvar g = 0; g < NE; g++) begin : g_cmp
        assign hit_vec[g] = (tags[g] == TAG_VALID) &&
                            (((mem[g] ^ comparand) & ~cmp_mask) == '0);
    end

    // Read ports
    always_comb begin
        ent_a = mem[rd_addr_a];
        tag_a = tags[rd_addr_a];
        ent_b = mem[rd_addr_b];
    end

endmodule

// File: rtl/tagcam_prio.sv
// Priority encoder over the hit vector: lowest set index, any-hit and
// more-than-one-hit flags. Index is zero when no bit is set.
module tagcam_prio #(
    parameter int NE = 16,
    localparam int AW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic [NE-1:0] vec,
    output logic          any,
    output logic          multi,
    output logic [AW-1:0] idx
);

    // Scan from the top so the lowest set bit wins
    always_comb begin
        idx = '0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (vec[i]) idx = AW'(i);
        end
    end

    // Flags: any set bit, and a second set bit left after clearing the lowest
    always_comb begin
        any   = |vec;
        multi = |(vec & (vec - NE'(1)));
    end

endmodule

// File: rtl/tagcam.sv
// Top of the tagged search array. Registers the search result one clock
// after a trigger, drives the flag outputs and the done pulse, and
// muxes the host read data. Reads are combinational.
module tagcam
    import tagcam_pkg::*;
#(
    parameter int DW = 128,
    parameter int HW = 32,
    parameter int NE = 16,
    localparam int NW = DW / HW,
    localparam int WIW = (NW > 1) ? $clog2(NW) : 1,
    localparam int AW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_sel,
    input  logic [AW-1:0]  wr_addr,
    input  logic [WIW-1:0] wr_word,
    input  logic [HW-1:0]  wr_data,
    input  logic           cmp_cmd,
    input  logic [1:0]     rd_sel,
    input  logic [AW-1:0]  rd_addr,
    input  logic [WIW-1:0] rd_word,
    output logic [HW-1:0]  rd_data,
    output logic           match,
    output logic           multi,
    output logic [AW-1:0]  hit_addr,
    output logic           done
);

    logic [DW-1:0] comparand, cmp_mask, wr_mask;
    logic          trig;
    logic [DW-1:0] ent_a, ent_b;
    logic [1:0]    tag_a;
    logic [NE-1:0] hit_vec;
    logic          p_any, p_multi;
    logic [AW-1:0] p_idx;
    logic          pend_q, done_q;
    logic          stat_match, stat_multi;
    logic [AW-1:0] stat_addr;
    logic [HW-1:0] stat_word;

    tagcam_regs #(.DW(DW), .HW(HW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_word(wr_word), .wr_data(wr_data), .cmp_cmd(cmp_cmd),
        .comparand(comparand), .cmp_mask(cmp_mask), .wr_mask(wr_mask),
        .trigger(trig)
    );

    tagcam_array #(.DW(DW), .HW(HW), .NE(NE)) u_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_word(wr_word), .wr_data(wr_data),
        .wr_mask(wr_mask), .comparand(comparand), .cmp_mask(cmp_mask),
        .rd_addr_a(rd_addr), .rd_addr_b(stat_addr),
        .ent_a(ent_a), .tag_a(tag_a), .ent_b(ent_b), .hit_vec(hit_vec)
    );

    tagcam_prio #(.NE(NE)) u_prio (
        .vec(hit_vec), .any(p_any), .multi(p_multi), .idx(p_idx)
    );

    // Delay the trigger one clock, capture the result, pulse done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q     <= 1'b0;
            done_q     <= 1'b0;
            stat_match <= 1'b0;
            stat_multi <= 1'b0;
            stat_addr  <= '0;
        end else begin
            pend_q <= trig;
            done_q <= pend_q;
            if (pend_q) begin
                stat_match <= p_any;
                stat_multi <= p_multi;
                stat_addr  <= p_idx;
            end
        end
    end

    // Build the status word: match bit 31, multi bit 30, address low
    always_comb begin
        stat_word           = '0;
        stat_word[HW-1]     = stat_match;
        stat_word[HW-2]     = stat_multi;
        stat_word[AW-1:0]   = stat_addr;
    end

    // Host read mux
    always_comb begin
        case (rd_sel)
            RD_STAT: rd_data = stat_word;
            RD_HIT:  rd_data = stat_match ? ent_b[rd_word*HW +: HW] : '0;
            RD_ENT:  rd_data = ent_a[rd_word*HW +: HW];
            default: rd_data = {{(HW-2){1'b0}}, tag_a};
        endcase
    end

    assign match    = stat_match;
    assign multi    = stat_multi;
    assign hit_addr = stat_addr;
    assign done     = done_q;

    a_r4_done_after_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> ##1 done);

    a_r4_done_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(trig, 2));

    a_r7_multi_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        multi |-> match);

    a_r8_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_q |=> ($stable(match) && $stable(multi) && $stable(hit_addr)));

endmodule

// File: tb/tb_tagcam.sv
`timescale 1ns/1ps
module tb_tagcam;

    localparam int DW = 128;
    localparam int HW = 32;
    localparam int NE = 16;
    localparam int NW = DW / HW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [3:0]  wr_addr = '0;
    logic [1:0]  wr_word = '0;
    logic [31:0] wr_data = '0;
    logic        cmp_cmd = 1'b0;
    logic [1:0]  rd_sel = '0;
    logic [3:0]  rd_addr = '0;
    logic [1:0]  rd_word = '0;
    logic [31:0] rd_data;
    logic        match, multi, done;
    logic [3:0]  hit_addr;

    int vec_n = 0;
    int bad_n = 0;

    // Bench model
    logic [127:0] m_ent [NE];
    logic [1:0]   m_tag [NE];
    logic [127:0] m_cmp, m_mska, m_mskb;
    logic [1:0]   m_ctrl;
    logic         e_match, e_multi;
    logic [3:0]   e_addr;

    always #5 clk = ~clk;

    tagcam dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_word(wr_word), .wr_data(wr_data),
        .cmp_cmd(cmp_cmd), .rd_sel(rd_sel), .rd_addr(rd_addr),
        .rd_word(rd_word), .rd_data(rd_data), .match(match),
        .multi(multi), .hit_addr(hit_addr), .done(done)
    );

    function automatic logic [127:0] dat(int i);
        logic [127:0] v;
        for (int w = 0; w < NW; w++)
            v[w*32 +: 32] = 32'h9E3779B9 * (i + 1) + 32'h7F4A7C15 * w;
        return v;
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        vec_n++;
        if (got !== exp) begin
            bad_n++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // Expected search result from the model
    task automatic model_search();
        logic [127:0] cm;
        int n;
        cm = (m_ctrl[0] ? 128'h0 : m_mska) | (m_ctrl[1] ? 128'h0 : m_mskb);
        n = 0;
        e_addr = 4'd0;
        for (int i = NE - 1; i >= 0; i--) begin
            if (m_tag[i] == 2'b00 && ((m_ent[i] ^ m_cmp) & ~cm) == 128'h0) begin
                n++;
                e_addr = 4'(i);
            end
        end
        e_match = (n > 0);
        e_multi = (n > 1);
    endtask

    // One host write; caller is at a falling edge, returns at the next one
    task automatic wr(logic [2:0] sel, logic [3:0] a, logic [1:0] w, logic [31:0] d);
        logic [127:0] wm;
        wm = (m_ctrl[0] ? m_mska : 128'h0) | (m_ctrl[1] ? m_mskb : 128'h0);
        case (sel)
            3'd0: m_cmp[w*32 +: 32] = d;
            3'd1: m_mska[w*32 +: 32] = d;
            3'd2: m_mskb[w*32 +: 32] = d;
            3'd3: m_ctrl = d[1:0];
            3'd4: m_ent[a][w*32 +: 32] =
                      (m_ent[a][w*32 +: 32] & wm[w*32 +: 32]) | (d & ~wm[w*32 +: 32]);
            3'd5: m_tag[a] = d[1:0];
            default: ;
        endcase
        wr_en = 1'b1; wr_sel = sel; wr_addr = a; wr_word = w; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] s, logic [3:0] a, logic [1:0] w, output logic [31:0] v);
        rd_sel = s; rd_addr = a; rd_word = w;
        #1;
        v = rd_data;
    endtask

    // Called at the falling edge right after the trigger edge
    task automatic check_result(string tag);
        logic [31:0] v;
        chk({"R4 no early done ", tag}, {31'b0, done}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        model_search();
        chk({"R4 done pulse ", tag}, {31'b0, done}, 32'd1);
        chk({"R7 match ", tag}, {31'b0, match}, {31'b0, e_match});
        chk({"R7 multi ", tag}, {31'b0, multi}, {31'b0, e_multi});
        chk({"R7 hit_addr ", tag}, {28'b0, hit_addr}, {28'b0, e_addr});
        rd(2'd0, 4'd0, 2'd0, v);
        chk({"R8 status word ", tag}, v, {e_match, e_multi, 26'b0, e_addr});
        @(posedge clk);
        @(negedge clk);
        chk({"R4 done single cycle ", tag}, {31'b0, done}, 32'd0);
        rd(2'd0, 4'd0, 2'd0, v);
        chk({"R8 status held ", tag}, v, {e_match, e_multi, 26'b0, e_addr});
    endtask

    // Load a 128-bit register; words 0..2 must not start a search
    task automatic load128(logic [2:0] sel, logic [127:0] val, string tag);
        for (int w = 0; w < NW - 1; w++) begin
            wr(sel, 4'd0, 2'(w), val[w*32 +: 32]);
            @(posedge clk);
            @(negedge clk);
            chk({"R3 lower word no search ", tag}, {31'b0, done}, 32'd0);
        end
        wr(sel, 4'd0, 2'(NW - 1), val[(NW-1)*32 +: 32]);
        check_result(tag);
    endtask

    task automatic strike(string tag);
        cmp_cmd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmp_cmd = 1'b0;
        check_result(tag);
    endtask

    task automatic write_entry(int i, logic [127:0] v);
        for (int w = 0; w < NW; w++) wr(3'd4, 4'(i), 2'(w), v[w*32 +: 32]);
    endtask

    task automatic check_entry(int i, string req);
        logic [31:0] v;
        for (int w = 0; w < NW; w++) begin
            rd(2'd2, 4'(i), 2'(w), v);
            chk(req, v, m_ent[i][w*32 +: 32]);
        end
    endtask

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NE; i++) begin
            m_ent[i] = '0;
            m_tag[i] = 2'b01;
        end
        m_cmp = '0; m_mska = '0; m_mskb = '0; m_ctrl = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 match after reset", {31'b0, match}, 32'd0);
        chk("R1 multi after reset", {31'b0, multi}, 32'd0);
        chk("R1 hit_addr after reset", {28'b0, hit_addr}, 32'd0);
        chk("R1 done after reset", {31'b0, done}, 32'd0);
        rst_n = 1'b1;
        rd(2'd0, 4'd0, 2'd0, v);
        chk("R1 status after reset", v, 32'd0);
        for (int i = 0; i < NE; i++) begin
            rd(2'd3, 4'(i), 2'd0, v);
            chk("R1 R10 tag empty after reset", v, 32'd1);
        end
        strike("R1 empty array no match");

        // Fill every entry, tag it valid, read back (R10)
        for (int i = 0; i < NE; i++) begin
            write_entry(i, dat(i));
            wr(3'd5, 4'(i), 2'd0, 32'd0);
        end
        for (int i = 0; i < NE; i++) begin
            check_entry(i, "R10 entry read");
            rd(2'd3, 4'(i), 2'd0, v);
            chk("R10 tag read valid", v, 32'd0);
        end

        // Search each entry by its own contents; read matched entry (R9)
        for (int i = 0; i < NE; i++) begin
            load128(3'd0, dat(i), "R3 comparand search");
            for (int w = 0; w < NW; w++) begin
                rd(2'd1, 4'd0, 2'(w), v);
                chk("R9 matched entry word", v, m_ent[i][w*32 +: 32]);
            end
        end

        // Tag sweep (R2): every entry through every code
        for (int i = 0; i < NE; i++) begin
            load128(3'd0, dat(i), "R2 comparand");
            for (int t = 1; t <= 4; t++) begin
                wr(3'd5, 4'(i), 2'd0, 32'(t & 3));
                rd(2'd3, 4'(i), 2'd0, v);
                chk("R10 tag readback", v, 32'(t & 3));
                strike("R2 tag code search");
            end
        end

        // Duplicates (R7)
        write_entry(9, dat(3));
        write_entry(12, dat(3));
        load128(3'd0, dat(3), "R7 three copies lowest");
        wr(3'd5, 4'd3, 2'd0, 32'd2);
        strike("R7 R2 skip lowest copy");
        wr(3'd5, 4'd9, 2'd0, 32'd3);
        strike("R7 R2 ram middle copy single");
        wr(3'd5, 4'd3, 2'd0, 32'd0);
        wr(3'd5, 4'd9, 2'd0, 32'd0);

        // Compare masking (R5): mask A hides upper 96 bits
        load128(3'd1, {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'h0}, "R5 R3 mask A load");
        load128(3'd0, {96'h12345678_DEADBEEF_0BADF00D, dat(7)[31:0]}, "R5 low word only");
        for (int w = 0; w < NW; w++) begin
            rd(2'd1, 4'd0, 2'(w), v);
            chk("R9 associated data outside mask", v, m_ent[7][w*32 +: 32]);
        end
        load128(3'd2, {96'h0, 32'hFFFFFFFF}, "R5 R7 all masked all match");
        wr(3'd3, 4'd0, 2'd0, 32'd2);
        check_result("R3 R6 control write B to write mode");
        wr(3'd3, 4'd0, 2'd0, 32'd3);
        check_result("R6 both write masks no search effect");
        rd(2'd1, 4'd0, 2'd0, v);
        chk("R9 no match reads zero", v, 32'd0);

        // Single-bit compare mask sweep over word 1 of entry 5
        wr(3'd3, 4'd0, 2'd0, 32'd0);
        check_result("R3 control back to compare");
        load128(3'd2, 128'h0, "R5 clear mask B");
        for (int b = 0; b < 32; b += 3) begin
            logic [127:0] c;
            c = dat(5);
            c[32 + b] = ~c[32 + b];
            load128(3'd1, 128'(1) << (32 + b), "R5 mask sweep");
            load128(3'd0, c, "R5 flipped bit masked");
            load128(3'd1, 128'h0, "R5 flipped bit unmasked");
        end

        // Write masking (R6)
        load128(3'd1, {96'hFFFFFFFF_FFFFFFFF_FFFFFFFF, 32'h0}, "R6 mask A pattern");
        wr(3'd3, 4'd0, 2'd0, 32'd1);
        check_result("R6 A to write mode");
        wr(3'd4, 4'd2, 2'd0, 32'hFFFFFFFF);
        wr(3'd4, 4'd2, 2'd3, 32'hFFFFFFFF);
        check_entry(2, "R6 protected word kept");
        wr(3'd3, 4'd0, 2'd0, 32'd0);
        check_result("R3 control compare");
        load128(3'd1, {4{32'h0F0F_0F0F}}, "R6 nibble mask");
        wr(3'd3, 4'd0, 2'd0, 32'd1);
        check_result("R6 nibble mask write mode");
        write_entry(4, {4{32'hFFFFFFFF}});
        check_entry(4, "R6 nibble protected bits");
        write_entry(11, {4{32'h00000000}});
        check_entry(11, "R6 nibble protected zeros");
        load128(3'd0, m_ent[4], "R6 write mask ignored by search");

        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad_n++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

endmodule